// File: doc/BRIEF.md
# Mailbox Request Framer and Response Validator

The block is the host-side engine for a byte-wide mailbox shared with a firmware microcontroller. One start strobe sends a framed request to the firmware. The frame is a four-byte header followed by payload bytes taken from a small local buffer, which the host loads beforehand. The engine paces each byte on the mailbox full flag.

When a response is expected, the engine then reads a four-byte response header, paced on the mailbox empty flag. It compares the opcode, module and length in that header with the values latched at start. On a match, the response payload streams out one byte per valid/ready beat. On a mismatch, the engine reads and discards as many bytes as the foreign header declares, so the mailbox is left clean, and then raises an error.

Each byte is polled every clock cycle. A per-byte wait limit turns a stuck mailbox into a timeout error. After a timeout the engine returns to idle at once.

Top module: `mbox_framer`

## Requirements
- R1: A request starts with four header bytes written in this order: opcode, module, length bits 15:8, length bits 7:0.
- R2: After the header, exactly `req_len` payload bytes are written, taken from buffer entries 0, 1, 2 and so on. With `rsp_en` low, `done` pulses for one cycle once the last byte is written.
- R3: `mb_wr` is asserted only in a cycle where `mb_full` is low, and `mb_rd` only in a cycle where `mb_empty` is low.
- R4: Only bits 7:0 of `mb_rdata` are used, both for header comparison and for payload. Bits 31:8 have no effect.
- R5: When the response header matches, exactly `exp_len` payload bytes are presented on `rsp_data` in arrival order. Each byte is held stable with `rsp_valid` high until `rsp_ready` is high. `done` pulses in the cycle after the last byte is accepted.
- R6: If the response opcode, module or 16-bit length differs from the expected value, the engine reads exactly the declared number of further bytes. It then pulses `err` with `err_cause` = 2 and asserts no `rsp_valid`.
- R7: If the mailbox flag blocks the current byte for `TMO_CYC` consecutive cycles, `err` pulses with `err_cause` = 1 and the engine returns to idle. With the full flag stuck from the start, `err` is high in the cycle after the (`TMO_CYC`+1)-th rising edge that follows the start cycle. No mailbox access follows.
- R8: A zero-length request writes only the four header bytes. A matching zero-length response ends with `done` right after the fourth header byte, with no payload beat.
- R9: A start strobe while the engine is busy is ignored and does not alter the transaction in progress.
- R10: After reset, `busy`, `done`, `err`, `mb_wr`, `mb_rd` and `rsp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pld_we | input | 1 | Payload buffer write enable |
| pld_addr | input | $clog2(PLD_DEPTH) | Payload buffer entry index |
| pld_wdata | input | 8 | Payload buffer write byte |
| start | input | 1 | Begin a transaction (taken only when idle) |
| req_op | input | 8 | Request opcode |
| req_mod | input | 8 | Request module identifier |
| req_len | input | 16 | Request payload length, at most PLD_DEPTH |
| rsp_en | input | 1 | Read and validate a response after the request |
| exp_op | input | 8 | Expected response opcode |
| exp_mod | input | 8 | Expected response module |
| exp_len | input | 16 | Expected response payload length |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle success strobe |
| err | output | 1 | One-cycle failure strobe |
| err_cause | output | 2 | 1 = timeout, 2 = response mismatch; valid with `err` |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_wdata | output | 8 | Mailbox write byte |
| mb_full | input | 1 | Mailbox cannot take a byte |
| mb_rd | output | 1 | Mailbox read strobe |
| mb_rdata | input | 32 | Mailbox read word, data in bits 7:0 |
| mb_empty | input | 1 | Mailbox has no byte to read |
| rsp_valid | output | 1 | Response payload byte available |
| rsp_data | output | 8 | Response payload byte |
| rsp_ready | input | 1 | Consumer accepts the byte |

## Verification
The checks assume the following about the mailbox and the consumer:
- `mb_rdata` carries the head byte in any cycle where `mb_empty` is low.
- The mailbox flags never show a byte that is not there.
- `req_len` stays within the buffer depth, and the buffer is not rewritten during a transaction.

The bench mailbox model honours these points. Its read side serves bytes from a preloaded array and reports empty once the array is used up. Its full and empty flags stall on fixed cycle patterns. All request lengths stay within the eight-entry buffer. The buffer is loaded only between transactions, and `rsp_ready` is toggled freely.

// File: rtl/mbox_framer.sv
`timescale 1ns/1ps
module mbox_framer #(
  parameter int PLD_DEPTH = 8,
  parameter int TMO_CYC   = 5000000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pld_we,
  input  logic [$clog2(PLD_DEPTH)-1:0] pld_addr,
  input  logic [7:0]                   pld_wdata,
  input  logic                         start,
  input  logic [7:0]                   req_op,
  input  logic [7:0]                   req_mod,
  input  logic [15:0]                  req_len,
  input  logic                         rsp_en,
  input  logic [7:0]                   exp_op,
  input  logic [7:0]                   exp_mod,
  input  logic [15:0]                  exp_len,
  output logic                         busy,
  output logic                         done,
  output logic                         err,
  output logic [1:0]                   err_cause,
  output logic                         mb_wr,
  output logic [7:0]                   mb_wdata,
  input  logic                         mb_full,
  output logic                         mb_rd,
  input  logic [31:0]                  mb_rdata,
  input  logic                         mb_empty,
  output logic                         rsp_valid,
  output logic [7:0]                   rsp_data,
  input  logic                         rsp_ready
);
  localparam int AW = $clog2(PLD_DEPTH);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [1:0] CAUSE_TMO = 2'd1;
  localparam logic [1:0] CAUSE_BAD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_TXH, S_TXP, S_RXH, S_DRN, S_RXP, S_HOLD} st_t;

  st_t         st;
  logic [7:0]  pbuf [PLD_DEPTH];
  logic [7:0]  op_q, mod_q, eop_q, emod_q, h0, h1, h2;
  logic [15:0] len_q, elen_q, dlen, idx;
  logic        ren_q;
  logic [TW-1:0] wcnt;
  logic        tx_st, rx_st, blocked, expire, bad_hdr, unused_hi;
  logic [7:0]  rb;
  logic [15:0] decl;

  assign unused_hi = ^mb_rdata[31:8];
  assign rb        = mb_rdata[7:0];
  assign decl      = {h2, rb};
  assign bad_hdr   = (h0 != eop_q) || (h1 != emod_q) || (decl != elen_q);

  assign tx_st   = (st == S_TXH) || (st == S_TXP);
  assign rx_st   = (st == S_RXH) || (st == S_DRN) || (st == S_RXP);
  assign blocked = (tx_st && mb_full) || (rx_st && mb_empty);
  assign expire  = blocked && (wcnt == TW'(TMO_CYC - 1));
  assign mb_wr   = tx_st && !mb_full;
  assign mb_rd   = rx_st && !mb_empty;
  assign busy    = (st != S_IDLE);

  always_comb begin
    mb_wdata = pbuf[idx[AW-1:0]];
    if (st == S_TXH) begin
      case (idx[1:0])
        2'd0:    mb_wdata = op_q;
        2'd1:    mb_wdata = mod_q;
        2'd2:    mb_wdata = len_q[15:8];
        default: mb_wdata = len_q[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pld_we) pbuf[pld_addr] <= pld_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      err_cause <= 2'd0;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'd0;
      idx       <= 16'd0;
      dlen      <= 16'd0;
      wcnt      <= '0;
      op_q      <= 8'd0;
      mod_q     <= 8'd0;
      len_q     <= 16'd0;
      ren_q     <= 1'b0;
      eop_q     <= 8'd0;
      emod_q    <= 8'd0;
      elen_q    <= 16'd0;
      h0        <= 8'd0;
      h1        <= 8'd0;
      h2        <= 8'd0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      wcnt <= blocked ? wcnt + 1'b1 : '0;
      if (expire) begin
        st        <= S_IDLE;
        err       <= 1'b1;
        err_cause <= CAUSE_TMO;
        rsp_valid <= 1'b0;
        wcnt      <= '0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            op_q   <= req_op;
            mod_q  <= req_mod;
            len_q  <= req_len;
            ren_q  <= rsp_en;
            eop_q  <= exp_op;
            emod_q <= exp_mod;
            elen_q <= exp_len;
            idx    <= 16'd0;
            st     <= S_TXH;
          end
          S_TXH, S_TXP: if (!mb_full) begin
            if ((st == S_TXH && idx == 16'd3 && len_q == 16'd0) ||
                (st == S_TXP && idx == len_q - 16'd1)) begin
              idx <= 16'd0;
              if (ren_q) st <= S_RXH;
              else begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            end else if (st == S_TXH && idx == 16'd3) begin
              idx <= 16'd0;
              st  <= S_TXP;
            end else begin
              idx <= idx + 16'd1;
            end
          end
          S_RXH: if (!mb_empty) begin
            case (idx[1:0])
              2'd0: h0 <= rb;
              2'd1: h1 <= rb;
              2'd2: h2 <= rb;
              default: ;
            endcase
            if (idx == 16'd3) begin
              idx <= 16'd0;
              if (bad_hdr) begin
                if (decl == 16'd0) begin
                  st        <= S_IDLE;
                  err       <= 1'b1;
                  err_cause <= CAUSE_BAD;
                end else begin
                  dlen <= decl;
                  st   <= S_DRN;
                end
              end else if (elen_q == 16'd0) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st <= S_RXP;
              end
            end else begin
              idx <= idx + 16'd1;
            end
          end
          S_DRN: if (!mb_empty) begin
            if (idx == dlen - 16'd1) begin
              st        <= S_IDLE;
              err       <= 1'b1;
              err_cause <= CAUSE_BAD;
            end else begin
              idx <= idx + 16'd1;
            end
          end
          S_RXP: if (!mb_empty) begin
            rsp_data  <= rb;
            rsp_valid <= 1'b1;
            st        <= S_HOLD;
          end
          S_HOLD: if (rsp_ready) begin
            rsp_valid <= 1'b0;
            if (idx == elen_q - 16'd1) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + 16'd1;
              st  <= S_RXP;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_framer_chk.sv
`timescale 1ns/1ps
module mbox_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_cause,
  input logic       mb_wr,
  input logic       mb_full,
  input logic       mb_rd,
  input logic       mb_empty,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       rsp_ready
);
  a_r3_wr_guard: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |-> !mb_full);
  a_r3_rd_guard: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |-> !mb_empty);
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r5_no_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mb_rd);
  a_r7_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_cause == 2'd1 || err_cause == 2'd2));
  a_r7_quiet_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mb_wr && !mb_rd && !rsp_valid));
  a_r10_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));
endmodule

bind mbox_framer mbox_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .err_cause(err_cause), .mb_wr(mb_wr), .mb_full(mb_full), .mb_rd(mb_rd),
  .mb_empty(mb_empty), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_ready(rsp_ready)
);

// File: tb/sim_mbox_framer.sv
`timescale 1ns/1ps
module sim_mbox_framer;
  localparam int PD  = 8;
  localparam int TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pld_we = 1'b0, start = 1'b0, rsp_en = 1'b0;
  logic [2:0] pld_addr = '0;
  logic [7:0] pld_wdata = '0, req_op = '0, req_mod = '0, exp_op = '0, exp_mod = '0;
  logic [15:0] req_len = '0, exp_len = '0;
  logic busy, done, err, mb_wr, mb_rd, rsp_valid, mb_full, mb_empty, rsp_ready;
  logic [1:0] err_cause;
  logic [7:0] mb_wdata, rsp_data;
  logic [31:0] mb_rdata;

  always #2 clk = ~clk;

  mbox_framer #(.PLD_DEPTH(PD), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .pld_we(pld_we), .pld_addr(pld_addr), .pld_wdata(pld_wdata),
    .start(start), .req_op(req_op), .req_mod(req_mod), .req_len(req_len), .rsp_en(rsp_en),
    .exp_op(exp_op), .exp_mod(exp_mod), .exp_len(exp_len), .busy(busy), .done(done),
    .err(err), .err_cause(err_cause), .mb_wr(mb_wr), .mb_wdata(mb_wdata), .mb_full(mb_full),
    .mb_rd(mb_rd), .mb_rdata(mb_rdata), .mb_empty(mb_empty), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ready(rsp_ready));

  logic [7:0] tx_log [4096];
  logic [7:0] rx_mem [4096];
  logic [7:0] got    [4096];
  int tx_n = 0, rx_n = 0, rx_ptr = 0, got_n = 0, viol = 0, cyc = 0;
  int full_mode = 0, emp_mode = 0, rdy_mode = 0;
  int nchk = 0, nerr = 0;
  int last_pe;
  logic last_done, last_err;
  logic [1:0] last_cause;

  always_comb begin
    mb_full   = (full_mode == 2) || (full_mode == 1 && cyc[0]);
    mb_empty  = (rx_ptr >= rx_n) || (emp_mode == 1 && cyc[1]);
    rsp_ready = (rdy_mode == 0) || cyc[0];
    mb_rdata  = {8'hC3, 8'h5A, 8'(~rx_ptr), rx_mem[rx_ptr[11:0]]};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mb_wr) begin tx_log[tx_n[11:0]] <= mb_wdata; tx_n <= tx_n + 1; end
    if (mb_rd) rx_ptr <= rx_ptr + 1;
    if (rsp_valid && rsp_ready) begin got[got_n[11:0]] <= rsp_data; got_n <= got_n + 1; end
    if ((mb_wr && mb_full) || (mb_rd && mb_empty)) viol <= viol + 1;
  end

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 29 + s * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_buf(input int s);
    for (int i = 0; i < PD; i++) begin
      @(negedge clk);
      pld_we = 1'b1; pld_addr = 3'(i); pld_wdata = pat(i, s);
    end
    @(negedge clk); pld_we = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_mem[rx_n[11:0]] = b;
    rx_n++;
  endtask

  task automatic push_rsp(input logic [7:0] op, input logic [7:0] md, input int n, input int s);
    push_rx(op); push_rx(md); push_rx(8'(n >> 8)); push_rx(8'(n));
    for (int i = 0; i < n; i++) push_rx(pat(i, s + 50));
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] md, input int len, input bit re,
                     input logic [7:0] eo, input logic [7:0] em, input int el);
    @(negedge clk);
    start = 1'b1; req_op = op; req_mod = md; req_len = 16'(len); rsp_en = re;
    exp_op = eo; exp_mod = em; exp_len = 16'(el);
    @(negedge clk);
    start = 1'b0;
    last_pe = 1;
    while (!done && !err && last_pe < 5000) begin @(negedge clk); last_pe++; end
    last_done = done; last_err = err; last_cause = err_cause;
    if (last_pe >= 5000) chk(0, "watchdog run", last_pe, 0);
  endtask

  task automatic check_req(input logic [7:0] op, input logic [7:0] md, input int len,
                           input int s, input int base, input string tag);
    chk(tx_n - base == 4 + len, {tag, " R2 byte count"}, tx_n - base, 4 + len);
    chk(tx_log[base[11:0]] == op && tx_log[12'(base + 1)] == md &&
        tx_log[12'(base + 2)] == 8'(len >> 8) && tx_log[12'(base + 3)] == 8'(len),
        {tag, " R1 header order"}, tx_log[base[11:0]], op);
    for (int i = 0; i < len; i++)
      chk(tx_log[12'(base + 4 + i)] == pat(i, s), {tag, " R2 payload byte"},
          tx_log[12'(base + 4 + i)], pat(i, s));
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int b, r, g;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mb_wr && !mb_rd && !rsp_valid, "R10 reset outputs",
        {busy, done, err, mb_wr, mb_rd, rsp_valid}, 0);
    rst_n = 1'b1;

    for (int fm = 0; fm < 2; fm++)
      for (int len = 0; len <= PD; len++) begin
        full_mode = fm;
        load_buf(len + fm * 11);
        b = tx_n;
        run(8'(8'h10 + len), 8'(8'h01 + fm), len, 1'b0, 8'h0, 8'h0, 0);
        chk(last_done && !last_err, len == 0 ? "R8 zero request done" : "R2 done", last_done, 1);
        check_req(8'(8'h10 + len), 8'(8'h01 + fm), len, len + fm * 11, b, "req");
      end
    full_mode = 0;

    for (int rm = 0; rm < 2; rm++)
      for (int el = 0; el <= 5; el++) begin
        emp_mode = rm; rdy_mode = rm; full_mode = rm;
        load_buf(el + 40);
        b = tx_n; r = rx_ptr; g = got_n;
        push_rsp(8'h21, 8'h01, el, el);
        run(8'h21, 8'h01, 2, 1'b1, 8'h21, 8'h01, el);
        check_req(8'h21, 8'h01, 2, el + 40, b, "rsp");
        chk(last_done && !last_err, el == 0 ? "R8 zero response done" : "R5 done", last_done, 1);
        chk(got_n - g == el, "R5 payload beats", got_n - g, el);
        chk(rx_ptr - r == 4 + el, "R5 bytes read", rx_ptr - r, 4 + el);
        for (int i = 0; i < el; i++)
          chk(got[12'(g + i)] == pat(i, el + 50), "R4 R5 payload byte low bits",
              got[12'(g + i)], pat(i, el + 50));
      end
    emp_mode = 0; rdy_mode = 0; full_mode = 0;

    for (int k = 0; k < 4; k++) begin
      int dl;
      dl = (k == 2) ? 3 : (k == 3 ? 0 : 2);
      r = rx_ptr; g = got_n;
      push_rsp(k == 0 ? 8'h77 : 8'h30, k == 1 ? 8'h09 : 8'h01, dl, k);
      run(8'h30, 8'h01, 0, 1'b1, 8'h30, 8'h01, k == 3 ? 1 : 2);
      chk(last_err && !last_done && last_cause == 2'd2, "R6 mismatch cause", last_cause, 2);
      chk(rx_ptr - r == 4 + dl, "R6 drained bytes", rx_ptr - r, 4 + dl);
      chk(got_n == g, "R6 no payload beat", got_n - g, 0);
    end

    full_mode = 2;
    b = tx_n;
    run(8'h44, 8'h01, 3, 1'b0, 8'h0, 8'h0, 0);
    chk(last_err && last_cause == 2'd1, "R7 write timeout cause", last_cause, 1);
    chk(last_pe == TMO + 1, "R7 timeout latency", last_pe, TMO + 1);
    chk(tx_n == b, "R7 nothing written", tx_n - b, 0);
    @(negedge clk);
    chk(!busy && !mb_wr && !mb_rd, "R7 idle after timeout", busy, 0);
    full_mode = 0;

    r = rx_ptr;
    push_rx(8'h50); push_rx(8'h01);
    run(8'h50, 8'h01, 0, 1'b1, 8'h50, 8'h01, 0);
    chk(last_err && last_cause == 2'd1, "R7 read timeout cause", last_cause, 1);
    chk(rx_ptr - r == 2, "R7 partial header read", rx_ptr - r, 2);

    full_mode = 1;
    load_buf(90);
    b = tx_n;
    @(negedge clk);
    start = 1'b1; req_op = 8'h61; req_mod = 8'h02; req_len = 16'd6; rsp_en = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; req_op = 8'hEE; req_len = 16'd0; rsp_en = 1'b1;
    @(negedge clk); start = 1'b0;
    last_pe = 0;
    while (!done && !err && last_pe < 5000) begin @(negedge clk); last_pe++; end
    chk(done && !err, "R9 first transaction completes", done, 1);
    check_req(8'h61, 8'h02, 6, 90, b, "R9");
    full_mode = 0;
    repeat (4) @(negedge clk);
    chk(!busy, "R9 no second transaction", busy, 0);

    chk(viol == 0, "R3 flag guard", viol, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule